// File: doc/BRIEF.md
# Per-Stream Ingress Filter with Sticky Oversize Blocking

This block sits in an ingress pipeline and makes the per-stream filtering decision for each frame. Every frame arrives with an ingress service index and its length. The service index selects, through a small mapping table, one stream filter identifier and, independently, one flow-meter index. The filter identifier addresses a filter table whose entries name the stream gate to use, a maximum service data unit (SDU) size, a block-oversize enable and a sticky block-oversize state. Two clock edges after the query the block returns the gate identifier, the flow-meter index and a drop verdict.

A frame longer than a non-zero maximum SDU is dropped. If the entry also has block-oversize enabled, that frame sets the entry's sticky state. From then on every frame that reaches the entry is dropped, whatever its size, until a configuration operation clears the state. A global enable decides whether the lookup is applied at all. When it is off, frames pass unfiltered and no state changes.

A single configuration port carries four operations. It writes the four filter fields of an entry, deletes an entry, writes a service-index mapping, or clears only the sticky state of an entry. The block has no state machine: it is a two-stage pipeline with two register tables.

Top module: `psf_stream_filter`

## Requirements
- R1: After reset `res_valid`, `res_drop` and `res_applied` are 0, and all mappings and filter entries are zero, so a frame on any service index passes with gate 0 and meter 0.
- R2: A query sampled with `q_valid` high at one rising edge produces exactly one result, with `res_valid` high, after the second rising edge. No result appears one edge after the query, and `res_drop` is 0 whenever `res_valid` is 0.
- R3: With the lookup enabled, `res_gate` is the gate field of the filter entry that the service index maps to, and `res_meter` is the meter index mapped to that service index. Both appear in the same cycle as the verdict.
- R4: With the lookup enabled, a frame whose length is greater than a non-zero maximum SDU is dropped. A frame whose length equals the maximum SDU passes.
- R5: A maximum SDU of zero disables the size check, so frames of any length pass while the sticky state is clear.
- R6: An oversize frame on an entry whose block-oversize enable is set sets that entry's sticky state. Every later frame reaching the entry is dropped regardless of length, including frames from other service indices mapped to it and a frame queried on the very next cycle.
- R7: An oversize frame on an entry whose block-oversize enable is clear is dropped but leaves no sticky state, so a following short frame passes.
- R8: The sticky state never clears by itself. Operation code 3 (clear state) clears only the sticky bit and keeps gate, maximum SDU and enable. Operation code 0 (filter write) sets all four fields from the port, so the state can also be written to 0 or 1 directly.
- R9: Operation code 1 (delete) writes gate, maximum SDU, enable and state of the addressed entry to zero. Operation code 2 (map write) sets the filter identifier and meter index of a service index.
- R10: When `lookup_en` is low at the query edge, the result has `res_applied` 0, `res_drop` 0, gate 0 and meter 0, and no sticky state is set.
- R11: When a configuration operation and a sticky-state set hit the same entry at the same edge, the configuration wins. The verdict computed at that edge uses the entry contents from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_en | input | 1 | Global enable of the service-index lookup and filtering |
| cfg_valid | input | 1 | Configuration operation strobe |
| cfg_op | input | 2 | 0 filter write, 1 delete, 2 map write, 3 clear state |
| cfg_isdx | input | ISDX_W (6) | Service index for map write |
| cfg_sfid | input | SF_W (10) | Filter identifier (entry address, or map target) |
| cfg_meter | input | METER_W (9) | Meter index for map write |
| cfg_gate | input | GATE_W (8) | Gate identifier for filter write |
| cfg_max_sdu | input | LEN_W (14) | Maximum SDU for filter write |
| cfg_blk_en | input | 1 | Block-oversize enable for filter write |
| cfg_blk_state | input | 1 | Sticky state value for filter write |
| q_valid | input | 1 | Frame query strobe |
| q_isdx | input | ISDX_W (6) | Service index of the frame |
| q_len | input | LEN_W (14) | Frame length in bytes |
| res_valid | output | 1 | Result strobe, two edges after the query |
| res_applied | output | 1 | Filtering was applied to this frame |
| res_drop | output | 1 | Drop verdict |
| res_gate | output | GATE_W (8) | Stream gate identifier |
| res_meter | output | METER_W (9) | Flow-meter index |

## Verification
Every result is due after the second rising edge that follows the query edge. The bench drives on falling edges and samples the result at the second falling edge after the query, and it also checks that nothing is reported at the first. Configuration writes take effect at the next rising edge. The bench updates its own model tables in the same order, and it applies each query's sticky update before predicting the next frame, which is exact for back-to-back queries because the state set by one frame is stored one edge before the next frame reads the entry. One directed case issues a clear-state operation on the edge where a frame sets the state, so that the configuration-wins rule of R11 is seen at the outputs.

// File: rtl/psf_pkg.sv
package psf_pkg;

    // Configuration operation codes carried on cfg_op
    typedef enum logic [1:0] {
        OP_SF_WRITE  = 2'd0,
        OP_SF_DELETE = 2'd1,
        OP_MAP_WRITE = 2'd2,
        OP_CLR_STATE = 2'd3
    } psf_op_e;

endpackage

// File: rtl/psf_isdx_map.sv
// Service-index mapping table plus the first pipeline stage.
module psf_isdx_map #(
    parameter int NUM_ISDX = 64,
    parameter int NUM_SF   = 1024,
    parameter int NUM_METER = 512,
    parameter int LEN_W    = 14,
    localparam int ISDX_W  = $clog2(NUM_ISDX),
    localparam int SF_W    = $clog2(NUM_SF),
    localparam int METER_W = $clog2(NUM_METER)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_we,
    input  logic [ISDX_W-1:0]  map_isdx,
    input  logic [SF_W-1:0]    map_sfid,
    input  logic [METER_W-1:0] map_meter,
    input  logic               q_valid,
    input  logic [ISDX_W-1:0]  q_isdx,
    input  logic [LEN_W-1:0]   q_len,
    input  logic               q_en,
    output logic               s1_valid,
    output logic               s1_en,
    output logic [SF_W-1:0]    s1_sfid,
    output logic [METER_W-1:0] s1_meter,
    output logic [LEN_W-1:0]   s1_len
);

    logic [SF_W-1:0]    sfid_tbl  [NUM_ISDX];
    logic [METER_W-1:0] meter_tbl [NUM_ISDX];

    // Mapping table storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ISDX; i++) begin
                sfid_tbl[i]  <= '0;
                meter_tbl[i] <= '0;
            end
        end else if (map_we) begin
            sfid_tbl[map_isdx]  <= map_sfid;
            meter_tbl[map_isdx] <= map_meter;
        end
    end

    // Stage 1 registers: lookup result of the query
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_en    <= 1'b0;
            s1_sfid  <= '0;
            s1_meter <= '0;
            s1_len   <= '0;
        end else begin
            s1_valid <= q_valid;
            s1_en    <= q_valid && q_en;
            s1_sfid  <= sfid_tbl[q_isdx];
            s1_meter <= meter_tbl[q_isdx];
            s1_len   <= q_len;
        end
    end

endmodule

// File: rtl/psf_filter_table.sv
// Filter entries: gate, maximum SDU, block enable, sticky block state.
module psf_filter_table
    import psf_pkg::*;
#(
    parameter int NUM_SF   = 1024,
    parameter int NUM_GATE = 256,
    parameter int LEN_W    = 14,
    localparam int SF_W    = $clog2(NUM_SF),
    localparam int GATE_W  = $clog2(NUM_GATE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  psf_op_e           cfg_op,
    input  logic [SF_W-1:0]   cfg_sfid,
    input  logic [GATE_W-1:0] cfg_gate,
    input  logic [LEN_W-1:0]  cfg_max_sdu,
    input  logic              cfg_blk_en,
    input  logic              cfg_blk_state,
    input  logic              set_en,
    input  logic [SF_W-1:0]   set_sfid,
    input  logic [SF_W-1:0]   rd_sfid,
    output logic [GATE_W-1:0] rd_gate,
    output logic [LEN_W-1:0]  rd_sdu,
    output logic              rd_blk_en,
    output logic              rd_state
);

    logic [GATE_W-1:0] gate_tbl [NUM_SF];
    logic [LEN_W-1:0]  sdu_tbl  [NUM_SF];
    logic              ben_tbl  [NUM_SF];
    logic              st_tbl   [NUM_SF];

    // Sticky set first, configuration afterwards so it takes priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SF; i++) begin
                gate_tbl[i] <= '0;
                sdu_tbl[i]  <= '0;
                ben_tbl[i]  <= 1'b0;
                st_tbl[i]   <= 1'b0;
            end
        end else begin
            if (set_en) begin
                st_tbl[set_sfid] <= 1'b1;
            end
            if (cfg_valid) begin
                unique case (cfg_op)
                    OP_SF_WRITE: begin
                        gate_tbl[cfg_sfid] <= cfg_gate;
                        sdu_tbl[cfg_sfid]  <= cfg_max_sdu;
                        ben_tbl[cfg_sfid]  <= cfg_blk_en;
                        st_tbl[cfg_sfid]   <= cfg_blk_state;
                    end
                    OP_SF_DELETE: begin
                        gate_tbl[cfg_sfid] <= '0;
                        sdu_tbl[cfg_sfid]  <= '0;
                        ben_tbl[cfg_sfid]  <= 1'b0;
                        st_tbl[cfg_sfid]   <= 1'b0;
                    end
                    OP_CLR_STATE: begin
                        st_tbl[cfg_sfid] <= 1'b0;
                    end
                    OP_MAP_WRITE: begin
                    end
                endcase
            end
        end
    end

    assign rd_gate   = gate_tbl[rd_sfid];
    assign rd_sdu    = sdu_tbl[rd_sfid];
    assign rd_blk_en = ben_tbl[rd_sfid];
    assign rd_state  = st_tbl[rd_sfid];

endmodule

// File: rtl/psf_size_check.sv
// Combinational size check and sticky-set decision for stage 2.
module psf_size_check #(
    parameter int LEN_W = 14
) (
    input  logic             s1_valid,
    input  logic             s1_en,
    input  logic [LEN_W-1:0] s1_len,
    input  logic [LEN_W-1:0] rd_sdu,
    input  logic             rd_blk_en,
    input  logic             rd_state,
    output logic             applied,
    output logic             drop,
    output logic             set_sticky
);

    logic oversize;

    always_comb begin
        applied    = s1_valid && s1_en;
        oversize   = (rd_sdu != '0) && (s1_len > rd_sdu);
        drop       = applied && (rd_state || oversize);
        set_sticky = applied && rd_blk_en && oversize;
    end

endmodule

// File: rtl/psf_stream_filter.sv
// Top: two-stage per-stream filter with sticky oversize blocking.
module psf_stream_filter
    import psf_pkg::*;
#(
    parameter int NUM_ISDX  = 64,
    parameter int NUM_SF    = 1024,
    parameter int NUM_GATE  = 256,
    parameter int NUM_METER = 512,
    parameter int LEN_W     = 14,
    localparam int ISDX_W   = $clog2(NUM_ISDX),
    localparam int SF_W     = $clog2(NUM_SF),
    localparam int GATE_W   = $clog2(NUM_GATE),
    localparam int METER_W  = $clog2(NUM_METER)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lookup_en,
    input  logic               cfg_valid,
    input  logic [1:0]         cfg_op,
    input  logic [ISDX_W-1:0]  cfg_isdx,
    input  logic [SF_W-1:0]    cfg_sfid,
    input  logic [METER_W-1:0] cfg_meter,
    input  logic [GATE_W-1:0]  cfg_gate,
    input  logic [LEN_W-1:0]   cfg_max_sdu,
    input  logic               cfg_blk_en,
    input  logic               cfg_blk_state,
    input  logic               q_valid,
    input  logic [ISDX_W-1:0]  q_isdx,
    input  logic [LEN_W-1:0]   q_len,
    output logic               res_valid,
    output logic               res_applied,
    output logic               res_drop,
    output logic [GATE_W-1:0]  res_gate,
    output logic [METER_W-1:0] res_meter
);

    psf_op_e op;
    logic    map_we;

    assign op     = psf_op_e'(cfg_op);
    assign map_we = cfg_valid && (op == OP_MAP_WRITE);

    logic               s1_valid;
    logic               s1_en;
    logic [SF_W-1:0]    s1_sfid;
    logic [METER_W-1:0] s1_meter;
    logic [LEN_W-1:0]   s1_len;

    logic [GATE_W-1:0]  rd_gate;
    logic [LEN_W-1:0]   rd_sdu;
    logic               rd_blk_en;
    logic               rd_state;

    logic               chk_applied;
    logic               chk_drop;
    logic               chk_set;

    psf_isdx_map #(
        .NUM_ISDX (NUM_ISDX),
        .NUM_SF   (NUM_SF),
        .NUM_METER(NUM_METER),
        .LEN_W    (LEN_W)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .map_we   (map_we),
        .map_isdx (cfg_isdx),
        .map_sfid (cfg_sfid),
        .map_meter(cfg_meter),
        .q_valid  (q_valid),
        .q_isdx   (q_isdx),
        .q_len    (q_len),
        .q_en     (lookup_en),
        .s1_valid (s1_valid),
        .s1_en    (s1_en),
        .s1_sfid  (s1_sfid),
        .s1_meter (s1_meter),
        .s1_len   (s1_len)
    );

    psf_filter_table #(
        .NUM_SF  (NUM_SF),
        .NUM_GATE(NUM_GATE),
        .LEN_W   (LEN_W)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_valid    (cfg_valid),
        .cfg_op       (op),
        .cfg_sfid     (cfg_sfid),
        .cfg_gate     (cfg_gate),
        .cfg_max_sdu  (cfg_max_sdu),
        .cfg_blk_en   (cfg_blk_en),
        .cfg_blk_state(cfg_blk_state),
        .set_en       (chk_set),
        .set_sfid     (s1_sfid),
        .rd_sfid      (s1_sfid),
        .rd_gate      (rd_gate),
        .rd_sdu       (rd_sdu),
        .rd_blk_en    (rd_blk_en),
        .rd_state     (rd_state)
    );

    psf_size_check #(
        .LEN_W(LEN_W)
    ) u_size (
        .s1_valid  (s1_valid),
        .s1_en     (s1_en),
        .s1_len    (s1_len),
        .rd_sdu    (rd_sdu),
        .rd_blk_en (rd_blk_en),
        .rd_state  (rd_state),
        .applied   (chk_applied),
        .drop      (chk_drop),
        .set_sticky(chk_set)
    );

    // Stage 2: result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_applied <= 1'b0;
            res_drop    <= 1'b0;
            res_gate    <= '0;
            res_meter   <= '0;
        end else begin
            res_valid   <= s1_valid;
            res_applied <= chk_applied;
            res_drop    <= chk_drop;
            res_gate    <= chk_applied ? rd_gate  : '0;
            res_meter   <= chk_applied ? s1_meter : '0;
        end
    end

endmodule

// File: rtl/psf_stream_filter_chk.sv
// Property checker attached to the top module.
module psf_stream_filter_chk #(
    parameter int LEN_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             q_valid,
    input logic             res_valid,
    input logic             res_applied,
    input logic             res_drop,
    input logic             s1_valid,
    input logic             s1_en,
    input logic [LEN_W-1:0] s1_len,
    input logic [LEN_W-1:0] rd_sdu,
    input logic             rd_state
);

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> ##2 res_valid);                                   // R2
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> ##2 !res_valid);                                 // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_drop && !res_applied));                  // R2
    AST_BYPASS_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !res_applied |-> !res_drop);                                  // R10
    AST_OVERSIZE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_en && rd_sdu != '0 && s1_len > rd_sdu) |=> res_drop); // R4
    AST_ZERO_SDU_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_en && rd_sdu == '0 && !rd_state) |=> !res_drop);      // R5
    AST_STICKY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_en && rd_state) |=> res_drop);                // R6

endmodule

bind psf_stream_filter psf_stream_filter_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_valid    (q_valid),
    .res_valid  (res_valid),
    .res_applied(res_applied),
    .res_drop   (res_drop),
    .s1_valid   (s1_valid),
    .s1_en      (s1_en),
    .s1_len     (s1_len),
    .rd_sdu     (rd_sdu),
    .rd_state   (rd_state)
);

// File: tb/psf_stream_filter_tb_top.sv
module psf_stream_filter_tb_top;

    localparam int NUM_ISDX = 64;
    localparam int NUM_SF   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lookup_en = 1'b1;
    logic        cfg_valid = 1'b0;
    logic [1:0]  cfg_op = '0;
    logic [5:0]  cfg_isdx = '0;
    logic [9:0]  cfg_sfid = '0;
    logic [8:0]  cfg_meter = '0;
    logic [7:0]  cfg_gate = '0;
    logic [13:0] cfg_max_sdu = '0;
    logic        cfg_blk_en = 1'b0;
    logic        cfg_blk_state = 1'b0;
    logic        q_valid = 1'b0;
    logic [5:0]  q_isdx = '0;
    logic [13:0] q_len = '0;
    logic        res_valid, res_applied, res_drop;
    logic [7:0]  res_gate;
    logic [8:0]  res_meter;

    int checks = 0;
    int errors = 0;

    // bench model tables
    int m_sf   [NUM_ISDX];
    int m_mt   [NUM_ISDX];
    int m_gate [NUM_SF];
    int m_sdu  [NUM_SF];
    bit m_ben  [NUM_SF];
    bit m_st   [NUM_SF];

    always #4 clk = ~clk;

    psf_stream_filter dut_i (
        .clk(clk), .rst_n(rst_n), .lookup_en(lookup_en),
        .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_isdx(cfg_isdx),
        .cfg_sfid(cfg_sfid), .cfg_meter(cfg_meter), .cfg_gate(cfg_gate),
        .cfg_max_sdu(cfg_max_sdu), .cfg_blk_en(cfg_blk_en),
        .cfg_blk_state(cfg_blk_state), .q_valid(q_valid), .q_isdx(q_isdx),
        .q_len(q_len), .res_valid(res_valid), .res_applied(res_applied),
        .res_drop(res_drop), .res_gate(res_gate), .res_meter(res_meter)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_over(input int len, input int sdu);
        return (sdu != 0) && (len > sdu);
    endfunction

    function automatic bit exp_drop(input int isdx, input int len, input bit en);
        int sf;
        sf = m_sf[isdx];
        return en && (m_st[sf] || is_over(len, m_sdu[sf]));
    endfunction

    // model update after a frame reached stage 2
    task automatic model_frame(input int isdx, input int len, input bit en);
        int sf;
        sf = m_sf[isdx];
        if (en && m_ben[sf] && is_over(len, m_sdu[sf])) m_st[sf] = 1'b1;
    endtask

    task automatic model_cfg(input int op, input int isdx, input int sf, input int mt,
                             input int gate, input int sdu, input bit ben, input bit bst);
        case (op)
            0: begin m_gate[sf] = gate; m_sdu[sf] = sdu; m_ben[sf] = ben; m_st[sf] = bst; end
            1: begin m_gate[sf] = 0; m_sdu[sf] = 0; m_ben[sf] = 0; m_st[sf] = 0; end
            2: begin m_sf[isdx] = sf; m_mt[isdx] = mt; end
            default: m_st[sf] = 1'b0;
        endcase
    endtask

    task automatic do_cfg(input int op, input int isdx, input int sf, input int mt,
                          input int gate, input int sdu, input bit ben, input bit bst);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_op = op[1:0]; cfg_isdx = isdx[5:0]; cfg_sfid = sf[9:0];
        cfg_meter = mt[8:0]; cfg_gate = gate[7:0]; cfg_max_sdu = sdu[13:0];
        cfg_blk_en = ben; cfg_blk_state = bst;
        @(negedge clk);
        cfg_valid = 1'b0;
        model_cfg(op, isdx, sf, mt, gate, sdu, ben, bst);
    endtask

    task automatic check_res(input string req, input int isdx, input int len, input bit en);
        check({req, " valid"}, res_valid, 1);
        check({req, " applied"}, res_applied, en);
        check({req, " drop"}, res_drop, exp_drop(isdx, len, en));
        check({req, " gate R3"}, res_gate, en ? m_gate[m_sf[isdx]] : 0);
        check({req, " meter R3"}, res_meter, en ? m_mt[isdx] : 0);
    endtask

    task automatic do_query(input string req, input int isdx, input int len, input bit en);
        @(negedge clk);
        q_valid = 1'b1; q_isdx = isdx[5:0]; q_len = len[13:0]; lookup_en = en;
        @(negedge clk);
        q_valid = 1'b0; lookup_en = 1'b1;
        check("R2 early result", res_valid, 0);
        @(negedge clk);
        check_res(req, isdx, len, en);
        model_frame(isdx, len, en);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NUM_ISDX; i++) begin m_sf[i] = 0; m_mt[i] = 0; end
        for (int i = 0; i < NUM_SF; i++) begin
            m_gate[i] = 0; m_sdu[i] = 0; m_ben[i] = 0; m_st[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", res_valid, 0);
        check("R1 drop", res_drop, 0);
        check("R1 applied", res_applied, 0);
        do_query("R1 default pass", 9, 1500, 1'b1);

        // R9 map write, R3 lookup
        do_cfg(2, 3, 10, 77, 0, 0, 0, 0);
        do_cfg(0, 0, 10, 0, 42, 100, 0, 0);
        do_query("R3 mapped", 3, 60, 1'b1);
        // R4 boundary
        do_query("R4 equal", 3, 100, 1'b1);
        do_query("R4 over", 3, 101, 1'b1);
        // R7 no sticky without enable
        do_query("R7 after oversize", 3, 20, 1'b1);
        // R5 zero SDU
        do_cfg(0, 0, 10, 0, 42, 0, 1, 0);
        do_query("R5 zero sdu", 3, 9000, 1'b1);

        // R6 sticky set; R10 disabled lookup sets nothing
        do_cfg(0, 0, 10, 0, 43, 100, 1, 0);
        do_query("R10 bypass", 3, 500, 1'b0);
        do_query("R10 no sticky after bypass", 3, 50, 1'b1);
        do_query("R6 trigger", 3, 500, 1'b1);
        do_query("R6 short dropped", 3, 10, 1'b1);
        do_cfg(2, 4, 10, 5, 0, 0, 0, 0);
        do_query("R6 other index dropped", 4, 10, 1'b1);
        repeat (20) @(negedge clk);
        do_query("R8 still set", 3, 1, 1'b1);
        // R8 clear state keeps other fields
        do_cfg(3, 0, 10, 0, 0, 0, 0, 0);
        do_query("R8 cleared", 3, 100, 1'b1);
        do_query("R8 size kept", 3, 101, 1'b1);
        do_query("R8 enable kept", 3, 5, 1'b1);
        do_cfg(0, 0, 10, 0, 43, 100, 1, 0);
        do_query("R8 write clears", 3, 5, 1'b1);

        // R6 back-to-back: second frame sees state set by first
        @(negedge clk);
        q_valid = 1'b1; q_isdx = 6'd3; q_len = 14'd300;
        @(negedge clk);
        q_isdx = 6'd3; q_len = 14'd30;
        @(negedge clk);
        q_valid = 1'b0;
        check_res("R6 pair first", 3, 300, 1'b1);
        model_frame(3, 300, 1'b1);
        @(negedge clk);
        check_res("R6 pair second", 3, 30, 1'b1);
        model_frame(3, 30, 1'b1);

        // R11 clear on the same edge as the sticky set
        do_cfg(3, 0, 10, 0, 0, 0, 0, 0);
        @(negedge clk);
        q_valid = 1'b1; q_isdx = 6'd3; q_len = 14'd400;
        @(negedge clk);
        q_valid = 1'b0;
        cfg_valid = 1'b1; cfg_op = 2'd3; cfg_sfid = 10'd10;
        @(negedge clk);
        cfg_valid = 1'b0;
        check("R11 verdict drop", res_drop, 1);
        do_query("R11 config wins", 3, 40, 1'b1);

        // R9 delete
        do_cfg(1, 0, 10, 0, 0, 0, 0, 0);
        do_query("R9 deleted", 3, 9000, 1'b1);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int pick, isdx, sf, len;
            pick = $urandom % 10;
            isdx = $urandom % 8;
            sf   = $urandom % 4;
            if (pick < 3) begin
                int op, sdu;
                op  = $urandom % 4;
                sdu = (($urandom % 4) == 0) ? 0 : ($urandom % 256);
                do_cfg(op, isdx, sf, $urandom % 512, $urandom % 256, sdu,
                       $urandom % 2, (($urandom % 8) == 0));
            end else begin
                len = $urandom % 300;
                do_query("R4 R6 random", isdx, len, (($urandom % 8) != 0));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule